// File: doc/BRIEF.md
# Camera Stream to Bit-Sliced SPI Memory Writer

This block moves one frame from an 8-bit parallel camera port into eight serial SPI memories that share a clock and a chip select. Each memory holds one bit position of every camera byte. Memory `i` stores bit `i` of each byte in order, so a later reader rebuilds byte `k` by taking bit `k` from each of the eight memories.

A transaction begins with a start request. The block lowers chip select and shifts a 32-bit header to all eight memories from its own divided bit clock. The header is the sequential-write opcode 0x02 followed by the 24-bit start address, most significant bit first, and every data line carries the same header bit. The block then waits until the frame sync line has been seen high. When it has, it moves the memory clock from its own bit clock to the camera pixel clock, gated by the line-valid signal. The move is made only while both clocks are low. From the next falling edge of frame sync, each rising pixel clock inside a valid line writes one bit into each memory. The memories stay in sequential mode and advance their address every eight bits. The frame ends on the rising edge of frame sync. At that point chip select is released, a one-cycle done pulse is given, and the number of captured bytes is held on an output. A full 352×240 frame at two bytes per pixel is 168,960 bytes, so each memory receives 168,960 payload bits.

Top module: `cam_bitslice_spi_writer`

## Requirements
- R1: In reset and after it, spi_cs_n is 1, spi_sck is 0, done is 0 and byte_count is 0.
- R2: A start request while idle drives spi_cs_n low on the next clock edge. spi_cs_n stays low without a break through the header and the capture, so there is exactly one chip-select falling edge per transaction.
- R3: The header is 32 rising edges of spi_sck. The bits are 0x02 and then the 24-bit start address, MSB first, and the same bit is on all eight spi_mosi lines. Each half period of the internal bit clock lasts DIV_HALF system clocks, the clock idles low, and spi_mosi is stable across each rising edge.
- R4: Capture starts only after frame sync has been seen high following the header. Pixel clocks of a frame that is already running when start arrives never reach spi_sck.
- R5: During capture, spi_sck equals cam_pclk AND cam_href, and spi_mosi[i] equals cam_data[i]. The memories therefore receive the frame's valid bytes in order, one byte per spi_sck rising edge, and the header plus N valid bytes gives exactly 32+N rising edges.
- R6: The rising edge of frame sync ends the capture. spi_cs_n returns to 1, and done is 1 for exactly one clock in the same cycle that spi_cs_n is 1. spi_sck then stays low and spi_cs_n stays high until the next start.
- R7: byte_count equals the number of gated pixel clocks in the captured frame and holds that value until the next accepted start.
- R8: A start request during a transaction is ignored. No second header is sent and the running capture is not disturbed.
- R9: A start request in the cycle where done is 1 is accepted and begins a new, correct transaction.
- R10: The memory clock source changes only while both clock sources are low, so no spi_sck edge appears while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to write one frame |
| start_addr | input | 24 | First memory address of the frame |
| cam_vsync | input | 1 | Camera frame sync, high between frames |
| cam_href | input | 1 | Camera line valid |
| cam_pclk | input | 1 | Camera pixel clock |
| cam_data | input | 8 | Camera pixel byte |
| spi_cs_n | output | 1 | Shared active-low chip select |
| spi_sck | output | 1 | Shared memory clock |
| spi_mosi | output | 8 | Data line to each memory, one per bit lane |
| done | output | 1 | One-cycle pulse when a frame is stored |
| byte_count | output | 20 | Bytes clocked in the last capture |

## Verification
Two events can land in the same clock: the end of one capture, when done pulses and chip select rises, and the acceptance of the next start request. The bench provokes this by raising start at the exact cycle in which it sees done. It then requires that spi_cs_n was high in that cycle, that exactly one new chip-select fall follows, and that the new header and frame arrive intact. The bench also injects start requests in the middle of a line and starts transactions in the middle of a running frame. In every case it rebuilds each memory's bit stream and compares it with header and pixel values computed from the run number.

// File: rtl/cswr_pkg.sv
package cswr_pkg;

    localparam logic [7:0] SEQ_WRITE_OP = 8'h02;
    localparam int         ADDR_BITS    = 24;
    localparam int         HEADER_BITS  = 8 + ADDR_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HEADER,
        ST_SEEK_HIGH,
        ST_SEEK_FALL,
        ST_CAPTURE
    } wr_state_t;

    typedef struct packed {
        logic [7:0]           op;
        logic [ADDR_BITS-1:0] addr;
    } header_t;

    function automatic header_t build_header(input logic [ADDR_BITS-1:0] a);
        header_t h;
        h.op   = SEQ_WRITE_OP;
        h.addr = a;
        return h;
    endfunction

endpackage

// File: rtl/cswr_sync.sv
module cswr_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cswr_header_shifter.sv
module cswr_header_shifter import cswr_pkg::*; #(
    parameter int DIV_HALF = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  logic [HEADER_BITS-1:0] word,
    output logic                   sck_o,
    output logic                   bit_o,
    output logic                   busy,
    output logic                   fin
);
    localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int BW = $clog2(HEADER_BITS + 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

    logic [HEADER_BITS-1:0] shreg;
    logic [BW-1:0]          bits_left;
    logic [DW-1:0]          div_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            bits_left <= '0;
            div_cnt   <= '0;
            sck_o     <= 1'b0;
            busy      <= 1'b0;
            fin       <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load && !busy) begin
                shreg     <= word;
                bits_left <= BW'(HEADER_BITS);
                div_cnt   <= '0;
                sck_o     <= 1'b0;
                busy      <= 1'b1;
            end else if (busy) begin
                if (div_cnt == DIV_LAST) begin
                    div_cnt <= '0;
                    if (!sck_o) begin
                        sck_o <= 1'b1;
                    end else begin
                        sck_o     <= 1'b0;
                        shreg     <= {shreg[HEADER_BITS-2:0], 1'b0};
                        bits_left <= bits_left - 1'b1;
                        if (bits_left == BW'(1)) begin
                            busy <= 1'b0;
                            fin  <= 1'b1;
                        end
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end
        end
    end

    assign bit_o = shreg[HEADER_BITS-1];

    assert_hdr_bit_stable_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sck_o) |-> $stable(bit_o));

    assert_hdr_idle_low_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sck_o);

endmodule

// File: rtl/cswr_clk_handover.sv
module cswr_clk_handover (
    input  logic clk,
    input  logic rst,
    input  logic want_cam,
    input  logic int_sck,
    input  logic cam_gck_s,
    output logic sel_cam
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_cam <= 1'b0;
        end else if ((want_cam != sel_cam) && !int_sck && !cam_gck_s) begin
            sel_cam <= want_cam;
        end
    end

    assert_switch_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (sel_cam != $past(sel_cam)) |-> (!$past(int_sck) && !$past(cam_gck_s)));

endmodule

// File: rtl/cam_bitslice_spi_writer.sv
module cam_bitslice_spi_writer import cswr_pkg::*; #(
    parameter int DIV_HALF    = 2,
    parameter int CNT_W       = 20,
    parameter int LANES       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [ADDR_BITS-1:0] start_addr,
    input  logic                 cam_vsync,
    input  logic                 cam_href,
    input  logic                 cam_pclk,
    input  logic [LANES-1:0]     cam_data,
    output logic                 spi_cs_n,
    output logic                 spi_sck,
    output logic [LANES-1:0]     spi_mosi,
    output logic                 done,
    output logic [CNT_W-1:0]     byte_count
);
    wr_state_t state;
    logic [1:0] sync_q;
    logic       vs_s, gck_s, gck_prev;
    logic       load, want_cam, sel_cam;
    logic       int_sck, cmd_bit, hdr_busy, hdr_fin;
    header_t    hdr;

    cswr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cam_vsync, cam_pclk & cam_href}),
        .q   (sync_q)
    );
    assign vs_s  = sync_q[1];
    assign gck_s = sync_q[0];

    assign load = (state == ST_IDLE) && start;
    assign hdr  = build_header(start_addr);

    cswr_header_shifter #(.DIV_HALF(DIV_HALF)) u_hdr (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .word  (hdr),
        .sck_o (int_sck),
        .bit_o (cmd_bit),
        .busy  (hdr_busy),
        .fin   (hdr_fin)
    );

    assign want_cam = (state == ST_SEEK_FALL) || (state == ST_CAPTURE);

    cswr_clk_handover u_mux (
        .clk       (clk),
        .rst       (rst),
        .want_cam  (want_cam),
        .int_sck   (int_sck),
        .cam_gck_s (gck_s),
        .sel_cam   (sel_cam)
    );

    assign spi_sck  = sel_cam ? (cam_pclk & cam_href) : int_sck;
    assign spi_mosi = sel_cam ? cam_data : {LANES{cmd_bit}};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            spi_cs_n   <= 1'b1;
            done       <= 1'b0;
            byte_count <= '0;
            gck_prev   <= 1'b0;
        end else begin
            done     <= 1'b0;
            gck_prev <= gck_s;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        spi_cs_n   <= 1'b0;
                        byte_count <= '0;
                        state      <= ST_HEADER;
                    end
                end
                ST_HEADER: begin
                    if (hdr_fin) state <= ST_SEEK_HIGH;
                end
                ST_SEEK_HIGH: begin
                    if (vs_s) state <= ST_SEEK_FALL;
                end
                ST_SEEK_FALL: begin
                    if (!vs_s && sel_cam) state <= ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    if (gck_s && !gck_prev) byte_count <= byte_count + 1'b1;
                    if (vs_s) begin
                        spi_cs_n <= 1'b1;
                        done     <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_cs_held_R2: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE) |-> !spi_cs_n);

    assert_header_tracked_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HEADER) |-> (hdr_busy || hdr_fin));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_on_vsync_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(vs_s));

    assert_count_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        ((state != ST_CAPTURE) && !load) |=> $stable(byte_count));

endmodule

// File: tb/cam_bitslice_spi_writer_test.sv
`timescale 1ns/1ps
module cam_bitslice_spi_writer_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [23:0] start_addr = '0;
    logic        cam_vsync = 1'b1;
    logic        cam_href = 1'b0;
    logic        cam_pclk = 1'b0;
    logic [7:0]  cam_data = '0;
    logic        spi_cs_n, spi_sck, done;
    logic [7:0]  spi_mosi;
    logic [19:0] byte_count;

    int checks = 0;
    int errors = 0;

    int          nbits = 0;
    int          ncs_falls = 0;
    int          stray = 0;
    logic [31:0] pre_lane [8];
    logic [7:0]  cap [64];

    always #5 clk = ~clk;

    cam_bitslice_spi_writer uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .cam_vsync(cam_vsync), .cam_href(cam_href), .cam_pclk(cam_pclk),
        .cam_data(cam_data), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .done(done), .byte_count(byte_count)
    );

    // memory model: one bit per lane per rising clock while selected
    always @(negedge spi_cs_n) begin
        nbits = 0;
        ncs_falls++;
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n === 1'b0) begin
            if (nbits < 32) begin
                for (int i = 0; i < 8; i++) pre_lane[i][31-nbits] = spi_mosi[i];
            end else if (nbits - 32 < 64) begin
                cap[nbits-32] = spi_mosi;
            end
            nbits++;
        end else if (spi_cs_n === 1'b1) begin
            stray++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int run, input int ln, input int col);
        return 8'((run * 53 + ln * 29 + col * 7 + 1) & 255);
    endfunction

    task automatic pclk_cycle(input logic h, input logic [7:0] d);
        cam_href = h;
        cam_data = d;
        #40 cam_pclk = 1'b1;
        #40 cam_pclk = 1'b0;
    endtask

    task automatic do_run(input int run, input logic [23:0] addr, input int lines,
                          input int bpl, input bit midframe, input bit poke,
                          input bit started, input bit chain, input logic [23:0] next_addr);
        bit seen;
        @(negedge clk);
        if (!started) begin
            start_addr = addr;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        if (midframe) begin
            cam_vsync = 1'b0;
            for (int c = 0; c < 20; c++) pclk_cycle(c >= 2 && c < 12, 8'hEE);
        end
        cam_vsync = 1'b1;
        for (int c = 0; c < 24; c++) pclk_cycle(1'b0, 8'h00);
        cam_vsync = 1'b0;
        pclk_cycle(1'b0, 8'h00);
        pclk_cycle(1'b0, 8'h00);
        for (int l = 0; l < lines; l++) begin
            for (int c = 0; c < bpl; c++) begin
                if (poke && l == 0 && c == 0) start = 1'b1;
                pclk_cycle(1'b1, pat(run, l, c));
                start = 1'b0;
            end
            pclk_cycle(1'b0, 8'h00);
            pclk_cycle(1'b0, 8'h00);
        end
        cam_vsync = 1'b1;
        seen = 1'b0;
        for (int w = 0; w < 100 && !seen; w++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen, "R6", "done pulse seen", seen, 1);
        check(spi_cs_n == 1'b1, "R6", "cs released with done", spi_cs_n, 1);
        for (int i = 0; i < 8; i++)
            check(pre_lane[i] == {8'h02, addr}, "R3", "header on lane", pre_lane[i], {8'h02, addr});
        check(nbits == 32 + lines * bpl, "R5", "clock edge total", nbits, 32 + lines * bpl);
        for (int k = 0; k < lines * bpl; k++)
            check(cap[k] == pat(run, k / bpl, k % bpl), midframe ? "R4" : "R5",
                  "stored byte", cap[k], pat(run, k / bpl, k % bpl));
        check(byte_count == 20'(lines * bpl), "R7", "byte count", byte_count, lines * bpl);
        check(ncs_falls == run + 1, poke ? "R8" : "R2", "cs falls", ncs_falls, run + 1);
        if (chain) begin
            start_addr = next_addr;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(done == 1'b0, "R9", "done width", done, 0);
        end else begin
            @(negedge clk);
            check(done == 1'b0, "R6", "done width", done, 0);
            repeat (16) @(negedge clk);
            check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R6", "idle after frame",
                  {spi_cs_n, spi_sck}, 2'b10);
            check(byte_count == 20'(lines * bpl), "R7", "count held", byte_count, lines * bpl);
        end
    endtask

    function automatic logic [23:0] addr_of(input int r);
        if (r < 24) return 24'(1) << r;
        if (r == 24) return 24'h000000;
        return 24'hFFFFFF;
    endfunction

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit chained;
        repeat (4) @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0, "R1", "in reset",
              {spi_cs_n, spi_sck, done}, 3'b100);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0 && byte_count == 0,
              "R1", "after reset", {spi_cs_n, spi_sck, done}, 3'b100);
        chained = 1'b0;
        for (int r = 0; r < 26; r++) begin
            bit ch;
            ch = (r % 3 == 0) && (r != 25);
            do_run(r, addr_of(r), 1 + r % 3, 1 + r % 5, r % 4 == 1, r % 5 == 2,
                   chained, ch, addr_of(r + 1));
            chained = ch;
        end
        check(stray == 0, "R10", "sck edges with cs high", stray, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule